// File: doc/BRIEF.md
# Gate-Delay Generator Command Controller

This block sits between a host register bus and a bank of timing channels, each with a programmable gate width and delay. The host never writes a channel directly. It first loads a data word, then a command word, and then pulses a start bit in the control register. A write operation can move the data word into one of two holding buffers, one for the gate and one for the delay. The same operation can then apply both buffers to a single channel or to every channel at once, clear all delays, or start a fixed-length calibration. A read operation copies one channel's gate or delay into a read-only result register.

A clock divider register sets the rate of a timing-clock enable strobe. The strobe pulses once every (value+1) cycles of the 50 MHz core clock. While an operation runs, the top bit of the control register reads 1, and any start request that arrives then is dropped.

Top module: `gdg_cmd_ctrl`

## Requirements
- R1: After a synchronous reset every host register reads zero, including the control busy bit, the result register and the divider. Every channel's gate and delay are zero.
- R2: The registers sit at byte addresses 0x1804 (divider, 32 bits), 0x7F00 (data word, 32 bits), 0x7F04 (command, only bits [15:0] are stored and bits [31:16] read 0) and 0x7F08 (control). 0x7F0C is the result register and ignores writes. Any other address reads zero.
- R3: In a write operation, command bits [15:12] = 0x2 load the low VAL_W bits of the data word into the gate buffer, and 0x3 load them into the delay buffer. Staging alone changes no channel.
- R4: In a write operation, command bits [11:8] = 0x1 copy both buffers into the channel given by command bits [7:0]. A value staged in the same operation is already included.
- R5: In a write operation, command bits [11:8] = 0x5 copy both buffers into every channel.
- R6: In a write operation, command bits [11:8] = 0x3 set every channel's delay to zero and leave every gate unchanged.
- R7: In a read operation, command bits [15:12] = 0x2 place the selected channel's gate in the result register, zero-extended, and 0x3 place its delay there. The holding buffers are not changed. The result is readable once busy has cleared.
- R8: A channel select of N_CH or more (with 32 channels, any of bits [7:5] set) is rejected. A commit to it modifies no channel, and a read of it returns zero.
- R9: Writing control bit 0 = 1 starts a write operation and bit 1 = 1 starts a read operation. The accepted start bit reads back as 1 for exactly one cycle and then clears by itself. Bit 31 reads 1 for exactly that one cycle for any operation other than calibrate.
- R10: Command bits [11:8] = 0x4 in a write operation start calibration. Busy then stays 1 for 1 + CAL_CYCLES cycles in total, and a start request written while busy has no effect.
- R11: If both control start bits are written as 1 together, only the write operation runs. The result register is left unchanged.
- R12: The output tclk_en pulses once every (divider+1) core cycles, so a value of 0 gives a pulse in every cycle. Writing the divider restarts the count, so the first pulse comes divider+1 cycles after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock (50 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Host register byte address |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for bus_addr, combinational |
| tclk_en | output | 1 | Timing-clock enable strobe from the divider |

## Verification
The bench builds the block with its defaults: 32 channels, 16-bit values and a 16-cycle calibration. With 32 channels the first rejected select is 0x20, which the bench drives against channel 0 so that a wrongly decoded select would show up as a change on that channel. The 16-bit value width lets a data word with its upper half set show the truncation. The short calibration allows the whole busy window to be counted one cycle at a time, with a start request dropped in the middle of it.

// File: rtl/gdg_pkg.sv
package gdg_pkg;

    localparam logic [15:0] ADDR_DIV  = 16'h1804;
    localparam logic [15:0] ADDR_DWR  = 16'h7F00;
    localparam logic [15:0] ADDR_CMD  = 16'h7F04;
    localparam logic [15:0] ADDR_CTRL = 16'h7F08;
    localparam logic [15:0] ADDR_DRD  = 16'h7F0C;

    localparam logic [3:0] STG_GATE = 4'h2;
    localparam logic [3:0] STG_DLY  = 4'h3;

    localparam logic [3:0] ACT_ONE  = 4'h1;
    localparam logic [3:0] ACT_RST  = 4'h3;
    localparam logic [3:0] ACT_CAL  = 4'h4;
    localparam logic [3:0] ACT_ALL  = 4'h5;

    typedef enum logic [1:0] {
        ST_NONE,
        ST_ONE,
        ST_ALL,
        ST_CLR_DLY
    } store_op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EXEC,
        S_CAL
    } seq_state_e;

    typedef struct packed {
        logic [3:0] stage;
        logic [3:0] act;
        logic [7:0] sel;
    } cmd_t;

    function automatic logic sel_in_range(input logic [7:0] sel, input int n_ch);
        return int'(sel) < n_ch;
    endfunction

endpackage

// File: rtl/gdg_clkdiv.sv
module gdg_clkdiv #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             div_wr,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || div_wr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R12
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && (div != '0) && !div_wr) |=> !tick);

endmodule

// File: rtl/gdg_store.sv
module gdg_store
    import gdg_pkg::*;
#(
    parameter int N_CH  = 32,
    parameter int VAL_W = 16,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  store_op_e        op,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [VAL_W-1:0] wr_gate,
    input  logic [VAL_W-1:0] wr_dly,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [VAL_W-1:0] rd_gate,
    output logic [VAL_W-1:0] rd_dly
);

    logic [VAL_W-1:0] gate_arr [N_CH];
    logic [VAL_W-1:0] dly_arr  [N_CH];

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic [VAL_W-1:0] gate_q;
        logic [VAL_W-1:0] dly_q;
        logic             hit;

        assign hit = (op == ST_ALL) || ((op == ST_ONE) && (wr_ch == CH_W'(i)));

        always_ff @(posedge clk) begin
            if (rst) begin
                gate_q <= '0;
                dly_q  <= '0;
            end else if (hit) begin
                gate_q <= wr_gate;
                dly_q  <= wr_dly;
            end else if (op == ST_CLR_DLY) begin
                dly_q  <= '0;
            end
        end

        assign gate_arr[i] = gate_q;
        assign dly_arr[i]  = dly_q;

        // R6
        gate_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (op == ST_CLR_DLY) |=> $stable(gate_q));
    end

    assign rd_gate = gate_arr[rd_ch];
    assign rd_dly  = dly_arr[rd_ch];

endmodule

// File: rtl/gdg_seq.sv
module gdg_seq
    import gdg_pkg::*;
#(
    parameter int N_CH       = 32,
    parameter int VAL_W      = 16,
    parameter int CAL_CYCLES = 16,
    localparam int CH_W      = $clog2(N_CH),
    localparam int CNT_W     = $clog2(CAL_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic [1:0]       ctrl_bits,
    input  cmd_t             cmd,
    input  logic [31:0]      data_word,
    input  logic [VAL_W-1:0] rd_gate,
    input  logic [VAL_W-1:0] rd_dly,
    output logic             busy,
    output logic [1:0]       pend,
    output logic [31:0]      rd_result,
    output store_op_e        st_op,
    output logic [CH_W-1:0]  st_ch,
    output logic [VAL_W-1:0] st_gate,
    output logic [VAL_W-1:0] st_dly
);

    seq_state_e       state;
    cmd_t             op_cmd;
    logic [VAL_W-1:0] op_data;
    logic             op_wr;
    logic [VAL_W-1:0] gate_buf;
    logic [VAL_W-1:0] dly_buf;
    logic [VAL_W-1:0] gate_nxt;
    logic [VAL_W-1:0] dly_nxt;
    logic [CNT_W-1:0] cal_cnt;
    logic             accept;
    logic             ch_ok;
    logic             exec_wr;
    logic             exec_rd;

    assign accept  = ctrl_wr && (state == S_IDLE) && (ctrl_bits != 2'b00);
    assign ch_ok   = sel_in_range(op_cmd.sel, N_CH);
    assign exec_wr = (state == S_EXEC) && op_wr;
    assign exec_rd = (state == S_EXEC) && !op_wr;
    assign busy    = (state != S_IDLE);

    always_comb begin
        gate_nxt = gate_buf;
        dly_nxt  = dly_buf;
        st_op    = ST_NONE;
        if (exec_wr) begin
            if (op_cmd.stage == STG_GATE) gate_nxt = op_data;
            if (op_cmd.stage == STG_DLY)  dly_nxt  = op_data;
            case (op_cmd.act)
                ACT_ONE: st_op = ch_ok ? ST_ONE : ST_NONE;
                ACT_ALL: st_op = ST_ALL;
                ACT_RST: st_op = ST_CLR_DLY;
                default: st_op = ST_NONE;
            endcase
        end
    end

    assign st_ch   = op_cmd.sel[CH_W-1:0];
    assign st_gate = gate_nxt;
    assign st_dly  = dly_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            op_cmd    <= '0;
            op_data   <= '0;
            op_wr     <= 1'b0;
            pend      <= 2'b00;
            gate_buf  <= '0;
            dly_buf   <= '0;
            rd_result <= '0;
            cal_cnt   <= '0;
        end else begin
            pend <= 2'b00;
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        state   <= S_EXEC;
                        op_cmd  <= cmd;
                        op_data <= data_word[VAL_W-1:0];
                        op_wr   <= ctrl_bits[0];
                        pend    <= ctrl_bits[0] ? 2'b01 : 2'b10;
                    end
                end
                S_EXEC: begin
                    gate_buf <= gate_nxt;
                    dly_buf  <= dly_nxt;
                    if (exec_rd) begin
                        if (op_cmd.stage == STG_GATE)
                            rd_result <= ch_ok ? 32'(rd_gate) : 32'd0;
                        else if (op_cmd.stage == STG_DLY)
                            rd_result <= ch_ok ? 32'(rd_dly) : 32'd0;
                    end
                    if (op_wr && (op_cmd.act == ACT_CAL)) begin
                        state   <= S_CAL;
                        cal_cnt <= CNT_W'(CAL_CYCLES - 1);
                    end else begin
                        state <= S_IDLE;
                    end
                end
                S_CAL: begin
                    if (cal_cnt == '0) state <= S_IDLE;
                    else               cal_cnt <= cal_cnt - 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (state == S_IDLE) && (rd_result == 32'd0) && (pend == 2'b00));

    // R9
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (pend != 2'b00) |=> (pend == 2'b00));

    // R10
    cal_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == S_CAL) && ctrl_wr) |=> (state != S_EXEC));

    // R11
    wr_first_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (ctrl_bits == 2'b11)) |=> (op_wr && (pend == 2'b01)));

    // R7
    rd_keeps_buf_chk: assert property (@(posedge clk) disable iff (rst)
        exec_rd |=> ($stable(gate_buf) && $stable(dly_buf)));

endmodule

// File: rtl/gdg_regs.sv
module gdg_regs
    import gdg_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      bus_addr,
    input  logic             bus_wr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             busy,
    input  logic [1:0]       pend,
    input  logic [31:0]      rd_result,
    output logic [DIV_W-1:0] div,
    output logic             div_wr,
    output logic [31:0]      data_word,
    output cmd_t             cmd,
    output logic             ctrl_wr,
    output logic [1:0]       ctrl_bits
);

    assign div_wr    = bus_wr && (bus_addr == ADDR_DIV);
    assign ctrl_wr   = bus_wr && (bus_addr == ADDR_CTRL);
    assign ctrl_bits = bus_wdata[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            div       <= '0;
            data_word <= '0;
            cmd       <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_DIV: div       <= bus_wdata[DIV_W-1:0];
                ADDR_DWR: data_word <= bus_wdata;
                ADDR_CMD: cmd       <= cmd_t'(bus_wdata[15:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_DIV:  bus_rdata = 32'(div);
            ADDR_DWR:  bus_rdata = data_word;
            ADDR_CMD:  bus_rdata = {16'd0, cmd};
            ADDR_CTRL: bus_rdata = {busy, 29'd0, pend};
            ADDR_DRD:  bus_rdata = rd_result;
            default:   bus_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/gdg_cmd_ctrl.sv
module gdg_cmd_ctrl
    import gdg_pkg::*;
#(
    parameter int N_CH       = 32,
    parameter int VAL_W      = 16,
    parameter int CAL_CYCLES = 16,
    parameter int DIV_W      = 32,
    localparam int CH_W      = $clog2(N_CH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tclk_en
);

    logic [DIV_W-1:0] div;
    logic             div_wr;
    logic [31:0]      data_word;
    cmd_t             cmd;
    logic             ctrl_wr;
    logic [1:0]       ctrl_bits;
    logic             busy;
    logic [1:0]       pend;
    logic [31:0]      rd_result;
    store_op_e        st_op;
    logic [CH_W-1:0]  st_ch;
    logic [VAL_W-1:0] st_gate;
    logic [VAL_W-1:0] st_dly;
    logic [VAL_W-1:0] rd_gate;
    logic [VAL_W-1:0] rd_dly;

    gdg_regs #(.DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .pend      (pend),
        .rd_result (rd_result),
        .div       (div),
        .div_wr    (div_wr),
        .data_word (data_word),
        .cmd       (cmd),
        .ctrl_wr   (ctrl_wr),
        .ctrl_bits (ctrl_bits)
    );

    gdg_seq #(
        .N_CH       (N_CH),
        .VAL_W      (VAL_W),
        .CAL_CYCLES (CAL_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .ctrl_bits (ctrl_bits),
        .cmd       (cmd),
        .data_word (data_word),
        .rd_gate   (rd_gate),
        .rd_dly    (rd_dly),
        .busy      (busy),
        .pend      (pend),
        .rd_result (rd_result),
        .st_op     (st_op),
        .st_ch     (st_ch),
        .st_gate   (st_gate),
        .st_dly    (st_dly)
    );

    gdg_store #(.N_CH(N_CH), .VAL_W(VAL_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .op      (st_op),
        .wr_ch   (st_ch),
        .wr_gate (st_gate),
        .wr_dly  (st_dly),
        .rd_ch   (st_ch),
        .rd_gate (rd_gate),
        .rd_dly  (rd_dly)
    );

    gdg_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
        .clk    (clk),
        .rst    (rst),
        .div    (div),
        .div_wr (div_wr),
        .tick   (tclk_en)
    );

endmodule

// File: tb/gdg_cmd_ctrl_tb.sv
module gdg_cmd_ctrl_tb;

    localparam int CLK_P = 10;
    localparam logic [15:0] A_DIV  = 16'h1804;
    localparam logic [15:0] A_DWR  = 16'h7F00;
    localparam logic [15:0] A_CMD  = 16'h7F04;
    localparam logic [15:0] A_CTRL = 16'h7F08;
    localparam logic [15:0] A_DRD  = 16'h7F0C;

    typedef struct packed {
        logic [31:0] data;
        logic [15:0] cmd;
        logic [1:0]  ctrl;
        logic        chk;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VT [NV] = '{
        {32'hFFFF1234, 16'h2000, 2'b01, 1'b0, 32'h0,    8'd3},  // R3 stage gate, upper half dropped
        {32'h00000056, 16'h3105, 2'b01, 1'b0, 32'h0,    8'd4},  // R4 stage delay + commit ch5
        {32'h0,        16'h2005, 2'b10, 1'b1, 32'h1234, 8'd4},
        {32'h0,        16'h3005, 2'b10, 1'b1, 32'h0056, 8'd7},  // R7 delay read
        {32'h0,        16'h2007, 2'b10, 1'b1, 32'h0,    8'd4},  // other channel untouched
        {32'h0000ABCD, 16'h2000, 2'b01, 1'b0, 32'h0,    8'd3},
        {32'h0,        16'h2005, 2'b10, 1'b1, 32'h1234, 8'd3},  // staging alone changes nothing
        {32'h0,        16'h0500, 2'b01, 1'b0, 32'h0,    8'd5},  // R5 broadcast
        {32'h0,        16'h201F, 2'b10, 1'b1, 32'hABCD, 8'd5},
        {32'h0,        16'h3000, 2'b10, 1'b1, 32'h0056, 8'd5},
        {32'h0,        16'h0300, 2'b01, 1'b0, 32'h0,    8'd6},  // R6 clear delays
        {32'h0,        16'h3009, 2'b10, 1'b1, 32'h0,    8'd6},
        {32'h0,        16'h2009, 2'b10, 1'b1, 32'hABCD, 8'd6},
        {32'h00007777, 16'h2120, 2'b01, 1'b0, 32'h0,    8'd8},  // R8 commit to ch 0x20
        {32'h0,        16'h2020, 2'b10, 1'b1, 32'h0,    8'd8},
        {32'h0,        16'h2000, 2'b10, 1'b1, 32'hABCD, 8'd8},
        {32'h00009999, 16'h2103, 2'b11, 1'b1, 32'hABCD, 8'd11}, // R11 both bits: write only
        {32'h0,        16'h2003, 2'b10, 1'b1, 32'h9999, 8'd11},
        {32'h0,        16'h3003, 2'b10, 1'b1, 32'h0056, 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        tclk_en;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    gdg_cmd_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tclk_en   (tclk_en)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    logic [31:0] v;
    int          nbusy;
    int          nticks;
    int          first;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_DIV, v);  check("R1 div", v, 32'h0);
        rd(A_DWR, v);  check("R1 data", v, 32'h0);
        rd(A_CMD, v);  check("R1 cmd", v, 32'h0);
        rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        rd(A_DRD, v);  check("R1 result", v, 32'h0);

        // R2 register map
        wr(A_DWR, 32'hDEADBEEF);  rd(A_DWR, v); check("R2 data rb", v, 32'hDEADBEEF);
        wr(A_CMD, 32'hFFFF2345);  rd(A_CMD, v); check("R2 cmd rb", v, 32'h00002345);
        wr(A_DRD, 32'h00000055);  rd(A_DRD, v); check("R2 result ro", v, 32'h0);
        rd(16'h0004, v);          check("R2 unmapped", v, 32'h0);
        wr(A_DIV, 32'h7);         rd(A_DIV, v); check("R2 div rb", v, 32'h7);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            wr(A_DWR, VT[i].data);
            wr(A_CMD, {16'h0, VT[i].cmd});
            wr(A_CTRL, {30'h0, VT[i].ctrl});
            @(negedge clk);
            if (VT[i].chk) begin
                rd(A_DRD, v);
                check($sformatf("R%0d vec%0d", VT[i].req, i), v, VT[i].exp);
            end
        end

        // R9 self-clearing start bit and one-cycle busy
        wr(A_CMD, 32'h00002005);
        wr(A_CTRL, 32'h2);
        rd(A_CTRL, v); check("R9 pend+busy", v, 32'h80000002);
        @(negedge clk);
        rd(A_CTRL, v); check("R9 cleared", v, 32'h0);
        rd(A_DRD, v);  check("R9 read done", v, 32'h0000ABCD);
        wr(A_CMD, 32'h00002003);
        wr(A_CTRL, 32'h2);
        @(negedge clk);
        rd(A_DRD, v);  check("R9 setup", v, 32'h00009999);

        // R10 calibrate busy window, start dropped while busy
        wr(A_CMD, 32'h00000400);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, v); check("R10 write pend", v, 32'h80000001);
        nbusy = 1;
        for (int k = 1; k < 40; k++) begin
            @(negedge clk);
            if (k == 3) begin
                bus_addr = A_CMD; bus_wdata = 32'h00002005; bus_wr = 1'b1;
                nbusy++;
            end else begin
                bus_wr = 1'b0;
                bus_addr = A_CTRL;
                bus_wdata = 32'h2;
                if (k == 5) bus_wr = 1'b1;
                #1;
                if (bus_rdata[31]) nbusy++;
            end
        end
        bus_wr = 1'b0;
        check("R10 busy cycles", 32'(nbusy), 32'd17);
        rd(A_DRD, v); check("R10 dropped read", v, 32'h00009999);
        wr(A_CTRL, 32'h2);
        @(negedge clk);
        rd(A_DRD, v); check("R10 later read", v, 32'h0000ABCD);

        // R12 divider
        wr(A_DIV, 32'h3);
        nticks = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); #1;
            if (tclk_en) nticks++;
        end
        check("R12 div3 rate", 32'(nticks), 32'd10);
        wr(A_DIV, 32'h0);
        nticks = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #1;
            if (tclk_en) nticks++;
        end
        check("R12 div0 rate", 32'(nticks), 32'd20);
        @(negedge clk);
        bus_addr = A_DIV; bus_wdata = 32'h4; bus_wr = 1'b1;
        first = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            #1;
            if (tclk_en && first == 0) first = k;
        end
        check("R12 restart", 32'(first), 32'd5);

        // R1 reset again clears the store
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        wr(A_CMD, 32'h0000201F);
        wr(A_CTRL, 32'h2);
        @(negedge clk);
        rd(A_DRD, v); check("R1 store cleared", v, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule